// File: doc/BRIEF.md
# Accelerator Bus Decode and Acknowledge

This block is the glue between a 32-bit processor with dynamic bus sizing and an older asynchronous 16-bit host motherboard. Each processor access is sorted into one of four targets: the host bus, a local fast RAM, a local 32-bit boot ROM, or nothing. Address ranges that belong to the host are decided by fixed windows, and one window depends on which host model is fitted. Local RAM and ROM ranges come from base and size parameters.

For host accesses the block drives a registered host address strobe and upper and lower byte strobes. The host's data acknowledge passes through a two-stage synchronizer and becomes the 16-bit port acknowledge. For local RAM and ROM the block makes the acknowledge itself with a shift register that runs while the processor address strobe is asserted. RAM answers after a fixed number of clocks. ROM answers after 3 or 4 clocks, depending on a configuration input, and reports a 32-bit port.

Top module: `accel_bus_glue`

## Requirements
- R1: Host window decode: while cpu_as_n is low, addresses 0x000000–0x1FFFFF and 0xDF0000–0xFFFFFF assert host_as_n low from the first rising edge on. Acknowledges on these addresses come only from the host.
- R2: Addresses 0x600000–0x9FFFFF go to the host only when host_model is 1. When host_model is 0 they hit no target.
- R3: Addresses 0xBFD000–0xBFFFFF go to the host only when address bit 0 is 0. Odd addresses in this range hit no target.
- R4: Byte strobes follow cpu_siz (01 byte, 10 word, 11 three-byte, 00 long) and address bit 0. host_uds_n is low when bit 0 is 0. host_lds_n is low when bit 0 is 1 or when the size is not byte.
- R5: On a host access, host_dtack_n is sampled through two flip-flops and then drives only cpu_dsack_n[1] low (cpu_dsack_n = 2'b01). cpu_dsack_n[0] never goes low for the host. A host acknowledge that arrives during a non-host access has no effect.
- R6: Fast RAM (default 0x200000–0x5FFFFF) drives cpu_dsack_n to 2'b00 from the third rising edge with cpu_as_n low.
- R7: Boot ROM (default 0xA00000–0xA7FFFF) drives cpu_dsack_n to 2'b00 from the third rising edge when rom_slow is 0, or from the fourth when rom_slow is 1. An aborted access leaves no count behind.
- R8: When cpu_as_n is high, cpu_dsack_n is 2'b11 in the same cycle. host_as_n, host_uds_n and host_lds_n are high after the next rising edge.
- R9: An access that hits no target leaves cpu_dsack_n at 2'b11 and all host strobes high, whatever host_dtack_n does.
- R10: While rst is high, all strobes and acknowledges are negated (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_addr | input | 24 | Processor byte address |
| cpu_siz | input | 2 | Processor transfer size code |
| host_model | input | 1 | 1 selects the host model that has the 0x600000 window |
| rom_slow | input | 1 | 1 selects 4-cycle ROM latency, 0 selects 3 |
| host_dtack_n | input | 1 | Asynchronous host data acknowledge, active low |
| host_as_n | output | 1 | Host address strobe, active low |
| host_uds_n | output | 1 | Host upper (even) byte strobe, active low |
| host_lds_n | output | 1 | Host lower (odd) byte strobe, active low |
| cpu_dsack_n | output | 2 | Port-size acknowledge to the processor, [1] 16-bit, [0] 8-bit, active low |

## Verification
Two sources can try to drive the port-size acknowledge in the same cycle: the synchronized host acknowledge and the local wait-state tap. The bench provokes this by holding host_dtack_n low for the whole of RAM and unmapped accesses. It then requires that cpu_dsack_n shows only the local timing, or stays 2'b11. The release of cpu_as_n can also coincide with an acknowledge that is just due. An aborted slow ROM access followed at once by a new one shows that the shift register was cleared and the full latency is counted again.

// File: rtl/glue_pkg.sv
package glue_pkg;

    localparam int ADDR_W = 24;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_HOST = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_ROM  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic uds_n;
        logic lds_n;
    } strobe_t;

    localparam logic [1:0] SIZ_LONG  = 2'b00;
    localparam logic [1:0] SIZ_BYTE  = 2'b01;
    localparam logic [1:0] SIZ_WORD  = 2'b10;
    localparam logic [1:0] SIZ_TRIPL = 2'b11;

    // Fixed host windows
    localparam logic [ADDR_W-1:0] LOWBANK_END  = 24'h1FFFFF;
    localparam logic [ADDR_W-1:0] MIDBANK_LO   = 24'h600000;
    localparam logic [ADDR_W-1:0] MIDBANK_HI   = 24'h9FFFFF;
    localparam logic [ADDR_W-1:0] PERIPH_LO    = 24'hBFD000;
    localparam logic [ADDR_W-1:0] PERIPH_HI    = 24'hBFFFFF;
    localparam logic [ADDR_W-1:0] TOPBANK_LO   = 24'hDF0000;

    function automatic logic in_span(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W:0]   lo,
                                     input logic [ADDR_W:0]   span);
        logic [ADDR_W:0] wa;
        wa = {1'b0, a};
        return (wa >= lo) && (wa < lo + span);
    endfunction

    function automatic logic is_periph(input logic [ADDR_W-1:0] a);
        return (a >= PERIPH_LO) && (a <= PERIPH_HI);
    endfunction

    function automatic logic is_midbank(input logic [ADDR_W-1:0] a);
        return (a >= MIDBANK_LO) && (a <= MIDBANK_HI);
    endfunction

    function automatic logic host_hit(input logic [ADDR_W-1:0] a,
                                      input logic              model);
        logic lo_b, mid_b, per_b, top_b;
        lo_b  = (a <= LOWBANK_END);
        mid_b = model && is_midbank(a);
        per_b = is_periph(a) && !a[0];
        top_b = (a >= TOPBANK_LO);
        return lo_b || mid_b || per_b || top_b;
    endfunction

    // Byte lanes on a 16-bit port for the first bus cycle of a transfer
    function automatic strobe_t lane_strobes(input logic       a0,
                                             input logic [1:0] siz);
        strobe_t s;
        s.uds_n = a0;
        s.lds_n = !(a0 || (siz != SIZ_BYTE));
        return s;
    endfunction

endpackage

// File: rtl/glue_decode.sv
module glue_decode
    import glue_pkg::*;
#(
    parameter logic [ADDR_W:0] RAM_BASE = 25'h0200000,
    parameter logic [ADDR_W:0] RAM_SIZE = 25'h0400000,
    parameter logic [ADDR_W:0] ROM_BASE = 25'h0A00000,
    parameter logic [ADDR_W:0] ROM_SIZE = 25'h0080000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_act,
    input  logic [ADDR_W-1:0] addr,
    input  logic              host_model,
    output tgt_e              tgt
);

    always_comb begin
        if (host_hit(addr, host_model))
            tgt = TGT_HOST;
        else if (in_span(addr, RAM_BASE, RAM_SIZE))
            tgt = TGT_RAM;
        else if (in_span(addr, ROM_BASE, ROM_SIZE))
            tgt = TGT_ROM;
        else
            tgt = TGT_NONE;
    end

    // R3: odd bytes of the peripheral window never reach the host
    p_odd_periph_r3: assert property (@(posedge clk) disable iff (rst)
        (as_act && is_periph(addr) && addr[0]) |-> (tgt == TGT_NONE));

    // R2: the middle window is closed for the host model without it
    p_midbank_model_r2: assert property (@(posedge clk) disable iff (rst)
        (as_act && !host_model && is_midbank(addr)) |-> (tgt != TGT_HOST));

endmodule

// File: rtl/glue_strobe.sv
module glue_strobe
    import glue_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       as_act,
    input  tgt_e       tgt,
    input  logic       a0,
    input  logic [1:0] siz,
    output logic       host_as_n,
    output strobe_t    lanes
);

    strobe_t lanes_next;

    always_comb lanes_next = lane_strobes(a0, siz);

    always_ff @(posedge clk) begin
        if (rst) begin
            host_as_n <= 1'b1;
            lanes     <= '{uds_n: 1'b1, lds_n: 1'b1};
        end else if (as_act && (tgt == TGT_HOST)) begin
            host_as_n <= 1'b0;
            lanes     <= lanes_next;
        end else begin
            host_as_n <= 1'b1;
            lanes     <= '{uds_n: 1'b1, lds_n: 1'b1};
        end
    end

    // R8: strobes drop one edge after the processor strobe goes away
    p_strobe_release_r8: assert property (@(posedge clk) disable iff (rst)
        !as_act |=> (host_as_n && lanes.uds_n && lanes.lds_n));

    // R4: an active host cycle always enables at least one lane
    p_lane_present_r4: assert property (@(posedge clk) disable iff (rst)
        !host_as_n |-> !(lanes.uds_n && lanes.lds_n));

endmodule

// File: rtl/glue_dtack_sync.sv
module glue_dtack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din_n,
    output logic dout_n
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din_n};
    end

    assign dout_n = chain[STAGES-1];

endmodule

// File: rtl/glue_waitgen.sv
module glue_waitgen #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_act,
    output logic [DEPTH-1:0] taps
);

    always_ff @(posedge clk) begin
        if (rst || !as_act) taps <= '0;
        else                taps <= {taps[DEPTH-2:0], 1'b1};
    end

    // R7: each tap is reached only after an uninterrupted run of strobe
    p_first_tap_r7: assert property (@(posedge clk) disable iff (rst)
        taps[0] |-> $past(as_act));

    for (genvar i = 1; i < DEPTH; i++) begin : g_tap_chk
        p_tap_chain_r7: assert property (@(posedge clk) disable iff (rst)
            taps[i] |-> $past(taps[i-1] && as_act));
    end

endmodule

// File: rtl/accel_bus_glue.sv
module accel_bus_glue
    import glue_pkg::*;
#(
    parameter logic [ADDR_W:0] RAM_BASE      = 25'h0200000,
    parameter logic [ADDR_W:0] RAM_SIZE      = 25'h0400000,
    parameter logic [ADDR_W:0] ROM_BASE      = 25'h0A00000,
    parameter logic [ADDR_W:0] ROM_SIZE      = 25'h0080000,
    parameter int              RAM_WAIT      = 3,
    parameter int              ROM_WAIT_FAST = 3,
    parameter int              ROM_WAIT_SLOW = 4,
    parameter int              SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_as_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_siz,
    input  logic              host_model,
    input  logic              rom_slow,
    input  logic              host_dtack_n,
    output logic              host_as_n,
    output logic              host_uds_n,
    output logic              host_lds_n,
    output logic [1:0]        cpu_dsack_n
);

    localparam int ROM_MAX = (ROM_WAIT_SLOW > ROM_WAIT_FAST) ? ROM_WAIT_SLOW : ROM_WAIT_FAST;
    localparam int DEPTH   = (RAM_WAIT > ROM_MAX) ? RAM_WAIT : ROM_MAX;

    logic             as_act;
    tgt_e             tgt;
    strobe_t          lanes;
    logic             dtack_s_n;
    logic [DEPTH-1:0] taps;
    logic             ram_due, rom_due;
    logic             host_ok, local_ok;

    assign as_act = !cpu_as_n;

    glue_decode #(
        .RAM_BASE(RAM_BASE), .RAM_SIZE(RAM_SIZE),
        .ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE)
    ) u_decode (
        .clk(clk), .rst(rst), .as_act(as_act), .addr(cpu_addr),
        .host_model(host_model), .tgt(tgt)
    );

    glue_strobe u_strobe (
        .clk(clk), .rst(rst), .as_act(as_act), .tgt(tgt),
        .a0(cpu_addr[0]), .siz(cpu_siz),
        .host_as_n(host_as_n), .lanes(lanes)
    );

    glue_dtack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din_n(host_dtack_n), .dout_n(dtack_s_n)
    );

    glue_waitgen #(.DEPTH(DEPTH)) u_wait (
        .clk(clk), .rst(rst), .as_act(as_act), .taps(taps)
    );

    assign host_uds_n = lanes.uds_n;
    assign host_lds_n = lanes.lds_n;

    always_comb begin
        ram_due  = taps[RAM_WAIT-1];
        rom_due  = rom_slow ? taps[ROM_WAIT_SLOW-1] : taps[ROM_WAIT_FAST-1];
        host_ok  = as_act && (tgt == TGT_HOST) && !host_as_n && !dtack_s_n;
        local_ok = as_act && (((tgt == TGT_RAM) && ram_due) ||
                              ((tgt == TGT_ROM) && rom_due));
        cpu_dsack_n[1] = !(host_ok || local_ok);
        cpu_dsack_n[0] = !local_ok;
    end

    // R5: the host never claims an 8-bit or 32-bit port
    p_host_word_only_r5: assert property (@(posedge clk) disable iff (rst)
        (tgt == TGT_HOST) |-> cpu_dsack_n[0]);

    // R5: a host acknowledge is seen only after two synchronizer edges
    p_sync_lag_r5: assert property (@(posedge clk) disable iff (rst)
        (!cpu_dsack_n[1] && (tgt == TGT_HOST)) |-> $past(!host_dtack_n, 2));

    // R9: unmapped accesses stay unacknowledged
    p_none_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (tgt == TGT_NONE) |-> (cpu_dsack_n == 2'b11));

    // R8: no acknowledge without a processor strobe
    p_dsack_drop_r8: assert property (@(posedge clk) disable iff (rst)
        cpu_as_n |-> (cpu_dsack_n == 2'b11));

    // R7: a ROM acknowledge needs at least three strobe edges behind it
    p_rom_min_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (!cpu_dsack_n[0] && (tgt == TGT_ROM)) |->
            ($past(as_act, 1) && $past(as_act, 2) && $past(as_act, 3)));

endmodule

// File: tb/test_accel_bus_glue.sv
module test_accel_bus_glue;

    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_as_n;
    logic [23:0] cpu_addr;
    logic [1:0]  cpu_siz;
    logic        host_model;
    logic        rom_slow;
    logic        host_dtack_n;
    logic        host_as_n, host_uds_n, host_lds_n;
    logic [1:0]  cpu_dsack_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    accel_bus_glue i_accel_bus_glue (
        .clk(clk), .rst(rst), .cpu_as_n(cpu_as_n), .cpu_addr(cpu_addr),
        .cpu_siz(cpu_siz), .host_model(host_model), .rom_slow(rom_slow),
        .host_dtack_n(host_dtack_n), .host_as_n(host_as_n),
        .host_uds_n(host_uds_n), .host_lds_n(host_lds_n),
        .cpu_dsack_n(cpu_dsack_n)
    );

    // addr[31:8] siz[7:6] model[5] slow[4] tgt[3:2] uds[1] lds[0]
    // tgt: 0 none, 1 host, 2 ram, 3 rom
    localparam logic [31:0] VECS [0:18] = '{
        {24'h000100, 2'b00, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
        {24'h1FFFFF, 2'b01, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0},
        {24'h0FFFFE, 2'b01, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1},
        {24'h123457, 2'b10, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0},
        {24'h200000, 2'b00, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1},
        {24'h5FFFFC, 2'b00, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1},
        {24'h600000, 2'b10, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
        {24'h600000, 2'b10, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1},
        {24'h9FFFFF, 2'b01, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0},
        {24'hA00000, 2'b00, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1},
        {24'hA7FFFC, 2'b00, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1},
        {24'hA80000, 2'b00, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1},
        {24'hBFD000, 2'b01, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1},
        {24'hBFD001, 2'b01, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1},
        {24'hBFEFFE, 2'b10, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
        {24'hDF0000, 2'b11, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},
        {24'hFFFFFF, 2'b01, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0},
        {24'hBFC000, 2'b10, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1},
        {24'hDEFFFF, 2'b01, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b time=%0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        cpu_as_n     = 1'b1;
        host_dtack_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [23:0] a, input logic [1:0] s,
                         input logic m, input logic sl);
        cpu_addr   = a;
        cpu_siz    = s;
        host_model = m;
        rom_slow   = sl;
        cpu_as_n   = 1'b0;
    endtask

    function automatic string req_of(input int t);
        case (t)
            1: return "R1/R2/R3/R4/R5 host";
            2: return "R6 ram";
            3: return "R7 rom";
            default: return "R9 none";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cpu_as_n = 1'b1; cpu_addr = '0; cpu_siz = 2'b00;
        host_model = 1'b0; rom_slow = 1'b0; host_dtack_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset idle", {host_as_n, host_uds_n, host_lds_n, 1'b1}, 4'b1111);
        check("R10 reset dsack", {2'b11, cpu_dsack_n}, 4'b1111);
        // R10: strobe during reset has no effect
        start(24'h000000, 2'b00, 1'b0, 1'b0);
        host_dtack_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 reset with access strobes", {host_as_n, host_uds_n, host_lds_n, 1'b1}, 4'b1111);
        check("R10 reset with access dsack", {2'b11, cpu_dsack_n}, 4'b1111);
        idle(1);
        rst = 1'b0;
        idle(3);

        // Vector walk
        for (int v = 0; v < 19; v++) begin
            logic [31:0] vec;
            int t, w;
            vec = VECS[v];
            t = int'(vec[3:2]);
            w = (t == 3 && vec[4]) ? 4 : 3;
            start(vec[31:8], vec[7:6], vec[5], vec[4]);
            for (int k = 1; k <= 5; k++) begin
                logic [1:0] ed;
                logic [2:0] es;
                @(negedge clk);
                es = (t == 1) ? {1'b0, vec[1], vec[0]} : 3'b111;
                if (t == 1)      ed = (k >= 3) ? 2'b01 : 2'b11;
                else if (t >= 2) ed = (k >= w) ? 2'b00 : 2'b11;
                else             ed = 2'b11;
                check({req_of(t), " strobes"}, {1'b1, host_as_n, host_uds_n, host_lds_n}, {1'b1, es});
                check({req_of(t), " dsack"}, {2'b11, cpu_dsack_n}, {2'b11, ed});
                if (k == 1 && t == 1) host_dtack_n = 1'b0;
            end
            cpu_as_n = 1'b1;
            host_dtack_n = 1'b1;
            #1;
            check("R8 dsack drops with strobe", {2'b11, cpu_dsack_n}, 4'b1111);
            @(negedge clk);
            check("R8 host strobes released", {1'b1, host_as_n, host_uds_n, host_lds_n}, 4'b1111);
            idle(3);
        end

        // R5: host access without any host acknowledge stays pending
        start(24'h000040, 2'b10, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        check("R5 host no dtack", {2'b11, cpu_dsack_n}, 4'b1111);
        check("R1 host strobe held", {1'b1, host_as_n, host_uds_n, host_lds_n}, 4'b1000);
        idle(3);

        // R5/R6: host dtack held low during RAM access must not speed it up
        start(24'h300000, 2'b00, 1'b0, 1'b0);
        host_dtack_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R5 dtack ignored in ram k2", {2'b11, cpu_dsack_n}, 4'b1111);
        @(negedge clk);
        check("R6 ram k3 with dtack low", {2'b11, cpu_dsack_n}, 4'b1100);
        idle(3);

        // R9: host dtack low during unmapped access
        start(24'hA80010, 2'b00, 1'b0, 1'b0);
        host_dtack_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 unmapped with dtack low", {2'b11, cpu_dsack_n}, 4'b1111);
        check("R9 unmapped no host strobe", {1'b1, host_as_n, host_uds_n, host_lds_n}, 4'b1111);
        idle(3);

        // R7: aborted slow ROM access, then a fresh one counts from zero
        start(24'hA00100, 2'b00, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        cpu_as_n = 1'b1;
        @(negedge clk);
        start(24'hA00100, 2'b00, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check("R7 rom restart k3 still waiting", {2'b11, cpu_dsack_n}, 4'b1111);
        @(negedge clk);
        check("R7 rom restart k4 ack", {2'b11, cpu_dsack_n}, 4'b1100);
        idle(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule